// File: doc/BRIEF.md
# Snapshot-Read Wide Time Base

This block keeps a wide free-running up-counter that advances on each enabled tick of a 24 MHz reference. The counter serves as a monotonic time base. It is read over a 32-bit register bus. One bus read cannot return the whole count, so software first asks for a snapshot. Software then reads the two halves of that snapshot, and both halves belong to the same instant.

A snapshot request is a write to the control register with the request bit set. The request bit then reads back as 1 while the capture is in flight. A fixed two-cycle delay models the crossing out of the counter's clock domain. When the bit reads 0 again, the holding register has the new value. Software then reads the low word and the high word in either order. A request that arrives while a capture is still pending is dropped.

Top module: `latched_timebase`

## Requirements
- R1: After a synchronous reset, the counter, the holding register and the request bit are all zero, so reads at 0xA0, 0xA4 and 0xA8 return 0.
- R2: The counter grows by exactly one on each clock edge where `tick_en` is high, holds its value when `tick_en` is low, and is cleared only by reset.
- R3: The counter wraps from all ones to zero; with `CNT_W` = 10 the snapshot after 1030 ticks reads 6.
- R4: A write to offset 0xA0 with bit 1 set starts a capture. Bit 1 of the word read at 0xA0 is then 1 for exactly the two cycles after the write edge, and 0 afterwards. All other bits of that word read 0.
- R5: The snapshot holds the counter value present between the first and the second clock edge after the request edge. Bits 31:0 of the snapshot read at 0xA4 and bits 63:32 read at 0xA8, zero-extended when `CNT_W` is below 64.
- R6: Reads at 0xA4 and 0xA8 return the held snapshot, not the live count, and stay unchanged until the next accepted capture completes.
- R7: A request written while a capture is pending is ignored. It neither lengthens the busy window nor moves the capture instant.
- R8: A write to 0xA0 with bit 1 clear, and any write to 0xA4, 0xA8 or another offset, has no effect. Reads at offsets other than 0xA0, 0xA4 and 0xA8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick enable; the counter advances when high |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 8 | Bus byte offset |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for `addr`, combinational |

## Verification
The live count is visible only through snapshots. A wrong counter step or a wrong capture instant therefore first shows in the words read at 0xA4 and 0xA8, right after the request bit at 0xA0 drops. A wrong busy length shows in the control word within three cycles of a request. A hold register that changes without a request shows at the next read of either data offset. Wrap-around is checked on a narrow instance so that it can be reached in a short run.

// File: rtl/tbase_pkg.sv
`timescale 1ns/1ps
package tbase_pkg;
    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int LATCH_BIT = 1;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_SNAP_LO = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_SNAP_HI = 8'hA8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LO,
        SEL_HI
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:    s = SEL_CTRL;
            OFS_SNAP_LO: s = SEL_LO;
            OFS_SNAP_HI: s = SEL_HI;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/tbase_counter.sv
`timescale 1ns/1ps
module tbase_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/tbase_snapshot.sv
`timescale 1ns/1ps
module tbase_snapshot #(
    parameter int CNT_W       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [CNT_W-1:0] live,
    output logic             busy,
    output logic [CNT_W-1:0] hold
);
    localparam int STG_W = $clog2(SYNC_STAGES + 1);
    localparam logic [STG_W-1:0] STG_LAST = STG_W'(SYNC_STAGES - 1);

    logic             busy_q;
    logic [STG_W-1:0] stage_q;
    logic [CNT_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            stage_q <= '0;
            hold_q  <= '0;
        end else if (!busy_q) begin
            if (req) begin
                busy_q  <= 1'b1;
                stage_q <= '0;
            end
        end else if (stage_q == STG_LAST) begin
            hold_q <= live;
            busy_q <= 1'b0;
        end else begin
            stage_q <= stage_q + 1'b1;
        end
    end

    assign busy = busy_q;
    assign hold = hold_q;

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |=> $stable(hold_q));

    // R7
    stage_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> stage_q <= STG_LAST);
endmodule

// File: rtl/tbase_regs.sv
`timescale 1ns/1ps
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  reg_sel_e         sel,
    input  logic             busy,
    input  logic [CNT_W-1:0] hold,
    output logic [BUS_W-1:0] rdata
);
    localparam int WIDE_W = 2 * BUS_W;

    logic [WIDE_W-1:0] wide;
    assign wide = WIDE_W'(hold);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: rdata[LATCH_BIT] = busy;
            SEL_LO:   rdata = wide[BUS_W-1:0];
            SEL_HI:   rdata = wide[WIDE_W-1:BUS_W];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/latched_timebase.sv
`timescale 1ns/1ps
module latched_timebase
    import tbase_pkg::*;
#(
    parameter int CNT_W       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata
);
    reg_sel_e         sel;
    logic             req;
    logic             busy;
    logic [CNT_W-1:0] live;
    logic [CNT_W-1:0] hold;
    logic             unused_wdata;

    assign sel          = decode_ofs(addr);
    assign req          = wr_en && (sel == SEL_CTRL) && wdata[LATCH_BIT];
    assign unused_wdata = ^{wdata[BUS_W-1:LATCH_BIT+1], wdata[LATCH_BIT-1:0]};

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_q   (live)
    );

    tbase_snapshot #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_snap (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .live (live),
        .busy (busy),
        .hold (hold)
    );

    tbase_regs #(.CNT_W(CNT_W)) u_regs (
        .sel   (sel),
        .busy  (busy),
        .hold  (hold),
        .rdata (rdata)
    );

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(busy, 2) && !$past(busy, 3));

    // R7
    busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr != OFS_CTRL && addr != OFS_SNAP_LO && addr != OFS_SNAP_HI) |-> rdata == '0);
endmodule

// File: tb/latched_timebase_bench.sv
`timescale 1ns/1ps
module latched_timebase_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] rdata_w;

    always #4 clk = ~clk;

    latched_timebase u_latched_timebase (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    latched_timebase #(.CNT_W(10)) u_latched_timebase_w (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_w)
    );

    // reference model built from the requirements
    logic [63:0] m_cnt, m_hold;
    logic        m_busy;
    int          m_stg;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_hold <= '0; m_busy <= 1'b0; m_stg <= 0;
        end else begin
            if (tick_en) m_cnt <= m_cnt + 64'd1;
            if (!m_busy) begin
                if (wr_en && addr == 8'hA0 && wdata[1]) begin
                    m_busy <= 1'b1; m_stg <= 0;
                end
            end else if (m_stg == 1) begin
                m_hold <= m_cnt; m_busy <= 1'b0;
            end else begin
                m_stg <= m_stg + 1;
            end
        end
    end

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R1";

    function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [63:0] h,
                                           input logic b);
        case (a)
            8'hA0:   return {30'd0, b, 1'b0};
            8'hA4:   return h[31:0];
            8'hA8:   return h[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input logic [7:0] a);
        logic [31:0] e, ew;
        addr = a;
        #0.5;
        e  = exp_rd(a, m_hold, m_busy);
        ew = exp_rd(a, {54'd0, m_hold[9:0]}, m_busy);
        n_vec++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", phase, a, rdata, e);
        end
        n_vec++;
        if (rdata_w !== ew) begin
            n_bad++;
            $display("FAIL %s narrow addr=%h actual=%h expected=%h", phase, a, rdata_w, ew);
        end
    endtask

    // one cycle: check outputs at the falling edge, then drive the next inputs
    task automatic cyc(input logic tk, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd);
        @(negedge clk);
        if (!rst) begin
            wr_en = 1'b0;
            cmp(8'hA0);
            cmp(8'hA4);
            cmp(8'hA8);
            cmp(8'h3C);   // R8 unmapped read
        end
        tick_en = tk; wr_en = wr; addr = a; wdata = wd;
    endtask

    task automatic idle(input logic tk, input int n);
        for (int i = 0; i < n; i++) cyc(tk, 1'b0, 8'h00, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; tick_en = 1'b1; wr_en = 1'b0; addr = 8'h00; wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        phase = "R1";
        idle(1'b0, 2);

        phase = "R2";
        idle(1'b1, 50);
        cyc(1'b1, 1'b1, 8'hA0, 32'h2);
        idle(1'b0, 4);
        cyc(1'b0, 1'b1, 8'hA0, 32'h2);
        idle(1'b1, 4);

        phase = "R4";
        cyc(1'b1, 1'b1, 8'hA0, 32'hFFFF_FFFF);
        idle(1'b1, 4);

        phase = "R7";
        cyc(1'b1, 1'b1, 8'hA0, 32'h2);
        cyc(1'b1, 1'b1, 8'hA0, 32'h2);
        cyc(1'b1, 1'b1, 8'hA0, 32'h2);
        idle(1'b1, 4);

        phase = "R8";
        cyc(1'b1, 1'b1, 8'hA0, 32'hFFFF_FFFD);
        cyc(1'b1, 1'b1, 8'hA4, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b1, 8'hA8, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b1, 8'h10, 32'h0000_0002);
        idle(1'b1, 3);

        phase = "R6";
        idle(1'b1, 20);

        phase = "R3";
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        idle(1'b1, 1029);
        cyc(1'b1, 1'b1, 8'hA0, 32'h2);   // narrow snapshot should read 1030 mod 1024 region
        idle(1'b0, 4);

        phase = "R5";
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            a = (sel < 5) ? 8'hA0 : (sel == 5) ? 8'hA4 : (sel == 6) ? 8'hA8 : 8'($urandom);
            cyc(1'($urandom), ($urandom_range(0, 3) == 0), a, $urandom);
        end
        idle(1'b0, 4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule